// File: doc/BRIEF.md
# Timer Master Trigger and Commutation Controller

This block is the master-side control slice of a timer. A three-bit mode field picks one internal timer event and drives it onto a registered trigger output that other timers listen to. A select bit decides whether each channel's DMA request comes from that channel's own capture/compare event or from the counter update event. The block also holds the per-channel output configuration: an enable bit, a complementary enable bit and a three-bit output-mode field.

Configuration writes to a channel can take effect at once. They can also be staged in a shadow copy and loaded into the active set together on a commutation event. A commutation event is a one-cycle software strobe or, when selected, a rising edge of the trigger input. Channels without a complementary output are never staged.

Staging is governed by a two-state machine. In `CM_DIRECT`, writes reach the active set directly, and the machine moves to `CM_SHADOW` when the shadow enable input is high. In `CM_SHADOW`, writes to complementary channels go only to the shadow copy, and a commutation event loads every shadow copy into the active set. The machine returns to `CM_DIRECT` when the shadow enable input is low. The state follows the shadow enable input with one clock of delay.

Top module: `tmr_master_ctl`

## Requirements
- R1: After reset the trigger output, all DMA requests, all active channel bits and output-mode fields, and the commutation flag are 0.
- R2: With mode 000, the trigger output goes high for one cycle, one clock after the cycle in which the software counter reset strobe is high.
- R3: With mode 001, the trigger output equals, one clock later, the counter enable OR (pause mode AND trigger input).
- R4: With mode 010, the trigger output is the update event delayed one clock. With mode 011, it is channel 0's capture/compare event delayed one clock, and other channels' events have no effect.
- R5: With modes 100, 101, 110 and 111, the trigger output is the reference compare output of channel 0, 1, 2 and 3 respectively, delayed one clock.
- R6: With the DMA select at 0, channel n's DMA request is channel n's capture/compare event delayed one clock. With it at 1, every request equals the update event delayed one clock.
- R7: In state CM_DIRECT, a write to channel n sets enable bit n, complementary enable bit n and output-mode field bits [3n+2:3n] to the written values one clock later.
- R8: In state CM_SHADOW, a write to a complementary channel leaves the active set unchanged. A software commutation strobe loads all shadow copies into the active set one clock later.
- R9: With the commutation source select at 1, a rising edge of the trigger input (high now, low one clock earlier) also loads the shadows. With the select at 0, the trigger input has no effect, and an input that stays high does not load again.
- R10: A write to a channel without a complementary output (channel 3 by default) takes effect one clock later in either state.
- R11: A commutation load sets the commutation flag. The flag stays set until a clear strobe arrives without a load in the same cycle; when a load and a clear share a cycle, the flag ends set.
- R12: When a write to a complementary channel and a commutation load happen in the same cycle, the active set takes the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trg_mode_i | input | 3 | Trigger output source mode |
| dma_upd_sel_i | input | 1 | DMA request source: 0 capture/compare, 1 update |
| shadow_en_i | input | 1 | Enable staging of channel configuration |
| com_trig_sel_i | input | 1 | Allow trigger input rising edge to commutate |
| sw_reset_i | input | 1 | Software counter reset strobe |
| cnt_en_i | input | 1 | Counter enable control bit |
| pause_mode_i | input | 1 | Slave pause mode active |
| trgi_i | input | 1 | Slave trigger input |
| upd_evt_i | input | 1 | Counter update event |
| cc_evt_i | input | NCH | Per-channel capture/compare events |
| oc_ref_i | input | 4 | Reference compare outputs of channels 0..3 |
| com_strobe_i | input | 1 | Software commutation strobe (one cycle) |
| wr_i | input | 1 | Channel configuration write strobe |
| wr_ch_i | input | CH_W | Channel index of the write |
| wr_en_i | input | 1 | Written enable bit |
| wr_nen_i | input | 1 | Written complementary enable bit |
| wr_ocm_i | input | 3 | Written output-mode field |
| com_flag_clr_i | input | 1 | Commutation flag clear strobe |
| trgo_o | output | 1 | Trigger output |
| dma_req_o | output | NCH | Per-channel DMA requests |
| ch_en_o | output | NCH | Active enable bits |
| ch_nen_o | output | NCH | Active complementary enable bits |
| ch_ocm_o | output | 3*NCH | Active output-mode fields, channel n at [3n+2:3n] |
| com_flag_o | output | 1 | Commutation flag |

## Verification
Two pairs of functions can fall in the same cycle. The first is a configuration write to a complementary channel together with a commutation load. The bench drives the write and the software strobe in one cycle and expects the freshly written value in the active set one clock later. The second is a load together with a flag clear. The bench asserts the strobe and the clear in one cycle and expects the flag to read 1. A reference model in the bench tracks the shadow and active copies from the requirements alone, and it checks every channel output on every cycle, so any wrong ordering between these two paths appears as a mismatch.

// File: rtl/tmr_mc_pkg.sv
package tmr_mc_pkg;

    localparam int OCM_W   = 3;
    localparam int NUM_REF = 4;

    typedef enum logic [2:0] {
        TM_RESET   = 3'b000,
        TM_ENABLE  = 3'b001,
        TM_UPDATE  = 3'b010,
        TM_CCPULSE = 3'b011,
        TM_REF0    = 3'b100,
        TM_REF1    = 3'b101,
        TM_REF2    = 3'b110,
        TM_REF3    = 3'b111
    } trg_mode_e;

    typedef enum logic {
        CM_DIRECT = 1'b0,
        CM_SHADOW = 1'b1
    } cm_state_e;

    typedef struct packed {
        logic             en;
        logic             nen;
        logic [OCM_W-1:0] ocm;
    } ch_cfg_t;

endpackage

// File: rtl/tmr_trgo_sel.sv
module tmr_trgo_sel
    import tmr_mc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [2:0]         mode_i,
    input  logic               sw_reset_i,
    input  logic               cnt_en_i,
    input  logic               pause_i,
    input  logic               trgi_i,
    input  logic               upd_i,
    input  logic               cc0_i,
    input  logic [NUM_REF-1:0] oc_ref_i,
    output logic               trgo_o
);

    logic src;

    always_comb begin
        src = 1'b0;
        unique case (trg_mode_e'(mode_i))
            TM_RESET:   src = sw_reset_i;
            TM_ENABLE:  src = cnt_en_i | (pause_i & trgi_i);
            TM_UPDATE:  src = upd_i;
            TM_CCPULSE: src = cc0_i;
            TM_REF0:    src = oc_ref_i[0];
            TM_REF1:    src = oc_ref_i[1];
            TM_REF2:    src = oc_ref_i[2];
            TM_REF3:    src = oc_ref_i[3];
            default:    src = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trgo_o <= 1'b0;
        else         trgo_o <= src;
    end

    // R4: update mode forwards the update event one clock later
    a_r4_update_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == TM_UPDATE) |=> (trgo_o == $past(upd_i)));

    // R5: reference modes forward the selected channel reference
    a_r5_ref_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i[2] |=> (trgo_o == $past(oc_ref_i[mode_i[1:0]])));

endmodule

// File: rtl/tmr_dma_req.sv
module tmr_dma_req #(
    parameter int NCH = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           upd_sel_i,
    input  logic           upd_i,
    input  logic [NCH-1:0] cc_i,
    output logic [NCH-1:0] req_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        req_o <= '0;
        else if (upd_sel_i) req_o <= {NCH{upd_i}};
        else                req_o <= cc_i;
    end

    // R6: update-sourced requests raise every channel
    a_r6_upd_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_sel_i && upd_i) |=> (&req_o));

    // R6: event-sourced requests follow the per-channel events
    a_r6_cc_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_sel_i |=> (req_o == $past(cc_i)));

endmodule

// File: rtl/tmr_commut.sv
module tmr_commut
    import tmr_mc_pkg::*;
#(
    parameter int             NCH       = 4,
    parameter logic [NCH-1:0] COMP_MASK = {1'b0, {(NCH-1){1'b1}}},
    localparam int            CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                shadow_en_i,
    input  logic                com_trig_sel_i,
    input  logic                trgi_i,
    input  logic                com_strobe_i,
    input  logic                wr_i,
    input  logic [CH_W-1:0]     wr_ch_i,
    input  ch_cfg_t             wr_cfg_i,
    input  logic                com_flag_clr_i,
    output ch_cfg_t [NCH-1:0]   act_o,
    output logic                com_flag_o
);

    cm_state_e state_q, state_d;
    logic      trgi_q;
    logic      trgi_rise;
    logic      com_evt;
    logic      direct_wr;
    logic      load_en;

    assign trgi_rise = trgi_i & ~trgi_q;
    assign com_evt   = com_strobe_i | (com_trig_sel_i & trgi_rise);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trgi_q <= 1'b0;
        else         trgi_q <= trgi_i;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CM_DIRECT;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_DIRECT: if (shadow_en_i)  state_d = CM_SHADOW;
            CM_SHADOW: if (!shadow_en_i) state_d = CM_DIRECT;
            default:   state_d = CM_DIRECT;
        endcase
    end

    // state outputs
    always_comb begin
        direct_wr = 1'b0;
        load_en   = 1'b0;
        unique case (state_q)
            CM_DIRECT: direct_wr = 1'b1;
            CM_SHADOW: load_en   = com_evt;
            default:   direct_wr = 1'b1;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic    hit;
        ch_cfg_t act_q;

        assign hit      = wr_i && (wr_ch_i == CH_W'(c));
        assign act_o[c] = act_q;

        if (COMP_MASK[c]) begin : g_comp
            ch_cfg_t sh_q;
            ch_cfg_t sh_nxt;

            assign sh_nxt = hit ? wr_cfg_i : sh_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= sh_nxt;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)               act_q <= '0;
                else if (direct_wr && hit) act_q <= wr_cfg_i;
                else if (load_en)          act_q <= sh_nxt;
            end
        end else begin : g_plain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)  act_q <= '0;
                else if (hit) act_q <= wr_cfg_i;
            end

            // R10: channels without a complementary output ignore staging
            a_r10_plain_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
                hit |=> (act_q == $past(wr_cfg_i)));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             com_flag_o <= 1'b0;
        else if (load_en)        com_flag_o <= 1'b1;
        else if (com_flag_clr_i) com_flag_o <= 1'b0;
    end

    // R8: staged configuration holds without an event or a write
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CM_SHADOW && !com_evt && !wr_i) |=> $stable(act_o));

    // R11: a load always leaves the flag set
    a_r11_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_en |=> com_flag_o);

    // R11: flag is sticky until cleared
    a_r11_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (com_flag_o && !com_flag_clr_i) |=> com_flag_o);

endmodule

// File: rtl/tmr_master_ctl.sv
module tmr_master_ctl
    import tmr_mc_pkg::*;
#(
    parameter int             NCH       = 4,
    parameter logic [NCH-1:0] COMP_MASK = {1'b0, {(NCH-1){1'b1}}},
    localparam int            CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [2:0]           trg_mode_i,
    input  logic                 dma_upd_sel_i,
    input  logic                 shadow_en_i,
    input  logic                 com_trig_sel_i,
    input  logic                 sw_reset_i,
    input  logic                 cnt_en_i,
    input  logic                 pause_mode_i,
    input  logic                 trgi_i,
    input  logic                 upd_evt_i,
    input  logic [NCH-1:0]       cc_evt_i,
    input  logic [NUM_REF-1:0]   oc_ref_i,
    input  logic                 com_strobe_i,
    input  logic                 wr_i,
    input  logic [CH_W-1:0]      wr_ch_i,
    input  logic                 wr_en_i,
    input  logic                 wr_nen_i,
    input  logic [OCM_W-1:0]     wr_ocm_i,
    input  logic                 com_flag_clr_i,
    output logic                 trgo_o,
    output logic [NCH-1:0]       dma_req_o,
    output logic [NCH-1:0]       ch_en_o,
    output logic [NCH-1:0]       ch_nen_o,
    output logic [NCH*OCM_W-1:0] ch_ocm_o,
    output logic                 com_flag_o
);

    ch_cfg_t            wr_cfg;
    ch_cfg_t [NCH-1:0]  act;

    assign wr_cfg = '{en: wr_en_i, nen: wr_nen_i, ocm: wr_ocm_i};

    tmr_trgo_sel u_trgo (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (trg_mode_i),
        .sw_reset_i (sw_reset_i),
        .cnt_en_i   (cnt_en_i),
        .pause_i    (pause_mode_i),
        .trgi_i     (trgi_i),
        .upd_i      (upd_evt_i),
        .cc0_i      (cc_evt_i[0]),
        .oc_ref_i   (oc_ref_i),
        .trgo_o     (trgo_o)
    );

    tmr_dma_req #(.NCH(NCH)) u_dma (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .upd_sel_i (dma_upd_sel_i),
        .upd_i     (upd_evt_i),
        .cc_i      (cc_evt_i),
        .req_o     (dma_req_o)
    );

    tmr_commut #(.NCH(NCH), .COMP_MASK(COMP_MASK)) u_com (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .shadow_en_i    (shadow_en_i),
        .com_trig_sel_i (com_trig_sel_i),
        .trgi_i         (trgi_i),
        .com_strobe_i   (com_strobe_i),
        .wr_i           (wr_i),
        .wr_ch_i        (wr_ch_i),
        .wr_cfg_i       (wr_cfg),
        .com_flag_clr_i (com_flag_clr_i),
        .act_o          (act),
        .com_flag_o     (com_flag_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign ch_en_o[c]                  = act[c].en;
        assign ch_nen_o[c]                 = act[c].nen;
        assign ch_ocm_o[c*OCM_W +: OCM_W]  = act[c].ocm;
    end

endmodule

// File: tb/sim_tmr_master_ctl.sv
module sim_tmr_master_ctl;
    import tmr_mc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam logic [NCH-1:0] COMP = 4'b0111;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] trg_mode = '0;
    logic dma_sel = 0, shadow_en = 0, com_sel = 0, sw_reset = 0, cnt_en = 0;
    logic pause = 0, trgi = 0, upd = 0, strobe = 0, wr = 0, wen = 0, wnen = 0, clr = 0;
    logic [NCH-1:0] cc = '0;
    logic [3:0] oc_ref = '0;
    logic [1:0] wch = '0;
    logic [2:0] wocm = '0;
    logic trgo, com_flag;
    logic [NCH-1:0] dma_req, ch_en, ch_nen;
    logic [NCH*3-1:0] ch_ocm;

    tmr_master_ctl u0 (
        .clk_i(clk), .rst_ni(rst_n), .trg_mode_i(trg_mode), .dma_upd_sel_i(dma_sel),
        .shadow_en_i(shadow_en), .com_trig_sel_i(com_sel), .sw_reset_i(sw_reset),
        .cnt_en_i(cnt_en), .pause_mode_i(pause), .trgi_i(trgi), .upd_evt_i(upd),
        .cc_evt_i(cc), .oc_ref_i(oc_ref), .com_strobe_i(strobe), .wr_i(wr),
        .wr_ch_i(wch), .wr_en_i(wen), .wr_nen_i(wnen), .wr_ocm_i(wocm),
        .com_flag_clr_i(clr), .trgo_o(trgo), .dma_req_o(dma_req), .ch_en_o(ch_en),
        .ch_nen_o(ch_nen), .ch_ocm_o(ch_ocm), .com_flag_o(com_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int cyc = 0, n_run = 0, n_fail = 0;
    bit done = 0;
    string cur = "R1";

    // bench model of staged and active channel state
    logic [NCH-1:0] m_en = '0, m_nen = '0, s_en = '0, s_nen = '0;
    logic [2:0] m_ocm [NCH], s_ocm [NCH];
    logic m_flag = 0, m_trgi_p = 0, m_sh = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pick(int kind);
        case (kind)
            0: return 32'(trgo);
            1: return 32'(dma_req);
            2: return 32'(ch_en);
            3: return 32'(ch_nen);
            4: return 32'(ch_ocm);
            default: return 32'(com_flag);
        endcase
    endfunction

    // monitor: pops due items and compares
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = pick(it.kind);
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(int kind, logic [31:0] exp, string req);
        item_t it;
        it.due = cyc + 1; it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // advance one cycle: update model from current inputs, queue channel checks
    task automatic step();
        logic rise, load;
        logic [11:0] ocm_v;
        rise = trgi & ~m_trgi_p;
        load = m_sh & (strobe | (com_sel & rise));
        for (int c = 0; c < NCH; c++) begin
            logic hit;
            hit = wr && (wch == 2'(c));
            if (COMP[c]) begin
                if (hit) begin s_en[c] = wen; s_nen[c] = wnen; s_ocm[c] = wocm; end
                if (!m_sh && hit) begin m_en[c] = wen; m_nen[c] = wnen; m_ocm[c] = wocm; end
                else if (load) begin m_en[c] = s_en[c]; m_nen[c] = s_nen[c]; m_ocm[c] = s_ocm[c]; end
            end else if (hit) begin
                m_en[c] = wen; m_nen[c] = wnen; m_ocm[c] = wocm;
            end
        end
        if (load) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        m_trgi_p = trgi;
        m_sh = shadow_en;
        for (int c = 0; c < NCH; c++) ocm_v[c*3 +: 3] = m_ocm[c];
        push(2, 32'(m_en), cur);
        push(3, 32'(m_nen), cur);
        push(4, 32'(ocm_v), cur);
        push(5, 32'(m_flag), cur);
        @(negedge clk);
        sw_reset = 0; strobe = 0; wr = 0; clr = 0;
    endtask

    task automatic write_ch(logic [1:0] ch, logic e, logic n, logic [2:0] o);
        wr = 1; wch = ch; wen = e; wnen = n; wocm = o;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_ocm[c] = '0; s_ocm[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur = "R1"; push(0, 0, "R1"); push(1, 0, "R1"); step();

        // R2 software reset pulse in mode 000
        cur = "R2"; trg_mode = 3'b000; sw_reset = 1; push(0, 1, "R2"); step();
        push(0, 0, "R2"); step();

        // R3 enable mode
        cur = "R3"; trg_mode = 3'b001; cnt_en = 1; push(0, 1, "R3"); step();
        cnt_en = 0; pause = 1; trgi = 1; push(0, 1, "R3"); step();
        pause = 0; push(0, 0, "R3"); step();
        trgi = 0; push(0, 0, "R3"); step();

        // R4 update and channel 0 pulse modes
        cur = "R4"; trg_mode = 3'b010; upd = 1; push(0, 1, "R4"); step();
        upd = 0; push(0, 0, "R4"); step();
        trg_mode = 3'b011; cc = 4'b0001; push(0, 1, "R4"); step();
        cc = 4'b1110; push(0, 0, "R4"); step();
        cc = '0;

        // R5 reference compare modes
        cur = "R5";
        for (int n = 0; n < 4; n++) begin
            trg_mode = 3'(4 + n); oc_ref = 4'(1 << n); push(0, 1, "R5"); step();
            oc_ref = ~4'(1 << n); push(0, 0, "R5"); step();
        end
        oc_ref = '0;

        // R6 DMA request source
        cur = "R6"; dma_sel = 0; cc = 4'b0101; upd = 1; push(1, 32'h5, "R6"); step();
        dma_sel = 1; cc = '0; push(1, 32'hF, "R6"); step();
        upd = 0; cc = 4'hF; push(1, 32'h0, "R6"); step();
        cc = '0; dma_sel = 0;

        // R7 direct writes
        cur = "R7"; write_ch(1, 1, 1, 3'd5); step();
        write_ch(0, 1, 0, 3'd2); step();

        // R8 staged writes loaded by strobe
        cur = "R8"; shadow_en = 1; step();
        write_ch(0, 0, 1, 3'd3); step();
        step();
        strobe = 1; step();

        // R9 trigger input edge as commutation source
        cur = "R9"; write_ch(1, 0, 0, 3'd6); step();
        com_sel = 0; trgi = 1; step();
        trgi = 0; step();
        com_sel = 1; step();
        trgi = 1; step();
        write_ch(1, 1, 1, 3'd7); step();
        trgi = 0; step();

        // R10 channel without complementary output
        cur = "R10"; write_ch(3, 1, 1, 3'd4); step();

        // R11 flag stickiness and set-over-clear
        cur = "R11"; clr = 1; step();
        step();
        strobe = 1; step();
        step(); step();
        strobe = 1; clr = 1; step();
        clr = 1; step();

        // R12 write and load in the same cycle
        cur = "R12"; write_ch(2, 1, 1, 3'd1); strobe = 1; step();
        shadow_en = 0; step();
        cur = "R7"; write_ch(2, 0, 1, 3'd2); step();
        step();

        done = 1;
        summary();
        $finish;
    end

endmodule